// File: doc/BRIEF.md
# UART Hardware Handshake Controller

This block sits next to a serial transmitter and receiver and handles the two handshake lines. The clear-to-send input is an asynchronous pin. It is synchronized and then used to decide when the transmitter may begin a new character. A character that has already started always runs to its end. The block issues a one-cycle start grant to the transmitter and learns that a character has finished from a one-cycle done pulse.

The single request-to-send output has two uses, chosen by a mode input. In receive-ready mode it tells the remote side whether the local receive buffer has room. The decision compares the free-space count against a threshold with hysteresis. In driver-enable mode it switches an external line transceiver on one clock before the first start bit. It keeps the transceiver on across back-to-back characters and switches it off once the last character's stop bit is done. Both pins have a polarity input. A value of 0 means active-low, which is the reset default.

Top module: `uart_flow_ctrl`

## Requirements
- R1: With `cfg_fc_en`=1, `tx_start` pulses only if the synchronized clear-to-send is asserted; while it is negated, a pending `tx_req` never produces `tx_start`.
- R2: A clear-to-send change at the pin reaches the start decision after SYNC_STAGES (default 2) flops. In receive-ready mode (`cfg_rts_mode`=0), with `tx_req` held, `tx_start` rises on the third clock edge after the pin asserts.
- R3: Clear-to-send negating while a character is in flight does not stop that character. When `tx_done` arrives with another character requested, no `tx_start` is issued until clear-to-send asserts again, with the same latency as R2.
- R4: In driver-enable mode (`cfg_rts_mode`=1), request-to-send asserts one clock before `tx_start` pulses.
- R5: In driver-enable mode, request-to-send stays asserted while a character is in flight. It negates in the cycle after `tx_done` when no further character is requested.
- R6: If `tx_req` is still high when `tx_done` pulses and clear-to-send is asserted, the next `tx_start` pulses in the very next cycle. In driver-enable mode, request-to-send stays asserted across the boundary. Each start is a single-cycle pulse.
- R7: In receive-ready mode, request-to-send negates one cycle after `rx_free` < `cfg_rx_thresh`. It asserts one cycle after `rx_free` > `cfg_rx_thresh`. When the two are equal it keeps its previous state.
- R8: In receive-ready mode, request-to-send ignores transmitter activity. In driver-enable mode, it ignores `rx_free`.
- R9: `cfg_rts_pol` and `cfg_cts_pol` set each pin's active level on their own: 0 means active-low and 1 means active-high.
- R10: With `cfg_fc_en`=0, clear-to-send is ignored. `tx_start` follows `tx_req` by one cycle in receive-ready mode, or by two cycles (after the lead cycle) in driver-enable mode.
- R11: During reset, `tx_start` is 0 and request-to-send sits at its negated level.
- R12: In driver-enable mode, a character held back by clear-to-send after `tx_done` keeps request-to-send asserted. If `tx_req` is withdrawn, request-to-send negates in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fc_en | input | 1 | 1 = clear-to-send gates character starts |
| cfg_rts_mode | input | 1 | 0 = receive-ready, 1 = driver-enable |
| cfg_rts_pol | input | 1 | Request-to-send active level (0 low, 1 high) |
| cfg_cts_pol | input | 1 | Clear-to-send active level (0 low, 1 high) |
| cfg_rx_thresh | input | FREE_W | Free-space threshold for receive-ready |
| rx_free | input | FREE_W | Free entries in the receive buffer |
| tx_req | input | 1 | A character is waiting to be sent |
| tx_done | input | 1 | One-cycle pulse: stop bit of current character finished |
| tx_start | output | 1 | One-cycle grant: transmitter drives the start bit |
| cts_pin | input | 1 | Asynchronous clear-to-send pin |
| rts_pin | output | 1 | Registered request-to-send pin |

## Verification
The assertions assume the configuration inputs stay unchanged while a character is pending or in flight. They also assume `tx_done` pulses only while a character is in flight, and never in the cycle right after its `tx_start`. Finally, they assume `tx_req` stays high until the start it asks for has been granted or deliberately withdrawn. The stimulus keeps to these limits in four ways. It changes mode and polarity only while the block is idle. It drives every input at the falling edge. It raises `tx_done` several cycles after each grant. It drops `tx_req` only after the grant it was waiting for.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

  typedef enum logic [1:0] {
    GS_IDLE   = 2'd0,
    GS_LEAD   = 2'd1,
    GS_FLIGHT = 2'd2,
    GS_GAP    = 2'd3
  } gate_st_e;

  typedef enum logic {
    RTS_RX_READY  = 1'b0,
    RTS_TX_ENABLE = 1'b1
  } rts_mode_e;

  // Pin level for a logical assertion: active_high=0 means active-low.
  function automatic logic pin_level(input logic asserted, input logic active_high);
    return ~(asserted ^ active_high);
  endfunction

endpackage

// File: rtl/ufc_sync.sv
module ufc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_val,
  input  logic d,
  output logic q
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES < 2) begin : g_bad_depth
      $error("ufc_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{rst_val}};
    else     chain <= {chain[LAST-1:0], d};
  end

  assign q = chain[LAST];

endmodule

// File: rtl/ufc_tx_gate.sv
module ufc_tx_gate
  import ufc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cts_ok,
  input  logic lead_en,
  input  logic tx_req,
  input  logic tx_done,
  output logic tx_start,
  output logic de_q,
  output logic de_nxt
);

  gate_st_e st_q, st_d;
  logic     start_q, start_d;

  always_comb begin
    st_d    = st_q;
    start_d = 1'b0;
    de_nxt  = de_q;
    unique case (st_q)
      GS_IDLE: begin
        if (tx_req && cts_ok) begin
          if (lead_en) begin
            st_d   = GS_LEAD;
            de_nxt = 1'b1;
          end else begin
            st_d    = GS_FLIGHT;
            start_d = 1'b1;
          end
        end
      end
      GS_LEAD: begin
        if (!tx_req) begin
          st_d   = GS_IDLE;
          de_nxt = 1'b0;
        end else if (cts_ok) begin
          st_d    = GS_FLIGHT;
          start_d = 1'b1;
        end
      end
      GS_FLIGHT: begin
        if (tx_done) begin
          if (tx_req && cts_ok) begin
            start_d = 1'b1;
          end else if (tx_req) begin
            st_d = GS_GAP;
          end else begin
            st_d   = GS_IDLE;
            de_nxt = 1'b0;
          end
        end
      end
      GS_GAP: begin
        if (!tx_req) begin
          st_d   = GS_IDLE;
          de_nxt = 1'b0;
        end else if (cts_ok) begin
          st_d    = GS_FLIGHT;
          start_d = 1'b1;
        end
      end
      default: begin
        st_d   = GS_IDLE;
        de_nxt = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= GS_IDLE;
      start_q <= 1'b0;
      de_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      de_q    <= de_nxt;
    end
  end

  assign tx_start = start_q;

  // R1: a grant only follows a cycle in which clear-to-send was usable
  p_start_needs_cts_r1: assert property (@(posedge clk) disable iff (rst)
    start_q |-> $past(cts_ok));

  // R4: in driver-enable mode the enable was already on one cycle earlier
  p_lead_before_start_r4: assert property (@(posedge clk) disable iff (rst)
    (lead_en && start_q) |-> $past(de_q));

  // R5: the enable drops only after a finished character or a withdrawn request
  p_de_drop_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(de_q) |-> $past(tx_done || !tx_req));

  // R6: every grant is a single-cycle pulse
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);

endmodule

// File: rtl/ufc_rx_ready.sv
module ufc_rx_ready #(
  parameter int FREE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FREE_W-1:0] rx_free,
  input  logic [FREE_W-1:0] thresh,
  output logic              rdy_nxt
);

  logic rdy_q;

  always_comb begin
    rdy_nxt = rdy_q;
    if (rx_free < thresh)      rdy_nxt = 1'b0;
    else if (rx_free > thresh) rdy_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= rdy_nxt;
  end

  // R7: ready falls only when space was below the threshold
  p_rdy_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_q) |-> $past(rx_free < thresh));

  // R7: ready rises only when space was above the threshold
  p_rdy_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> $past(rx_free > thresh));

endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import ufc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FREE_W      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_fc_en,
  input  logic              cfg_rts_mode,
  input  logic              cfg_rts_pol,
  input  logic              cfg_cts_pol,
  input  logic [FREE_W-1:0] cfg_rx_thresh,
  input  logic [FREE_W-1:0] rx_free,
  input  logic              tx_req,
  input  logic              tx_done,
  output logic              tx_start,
  input  logic              cts_pin,
  output logic              rts_pin
);

  logic cts_raw_s;
  logic cts_ok;
  logic lead_en;
  logic de_q;
  logic de_nxt;
  logic rdy_nxt;
  logic rts_q;

  ufc_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (
    .clk     (clk),
    .rst     (rst),
    .rst_val (~cfg_cts_pol),
    .d       (cts_pin),
    .q       (cts_raw_s)
  );

  assign cts_ok  = !cfg_fc_en || (cts_raw_s == cfg_cts_pol);
  assign lead_en = (cfg_rts_mode == RTS_TX_ENABLE);

  ufc_tx_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .cts_ok   (cts_ok),
    .lead_en  (lead_en),
    .tx_req   (tx_req),
    .tx_done  (tx_done),
    .tx_start (tx_start),
    .de_q     (de_q),
    .de_nxt   (de_nxt)
  );

  ufc_rx_ready #(.FREE_W(FREE_W)) u_rx_ready (
    .clk     (clk),
    .rst     (rst),
    .rx_free (rx_free),
    .thresh  (cfg_rx_thresh),
    .rdy_nxt (rdy_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) rts_q <= ~cfg_rts_pol;
    else     rts_q <= pin_level(lead_en ? de_nxt : rdy_nxt, cfg_rts_pol);
  end

  assign rts_pin = rts_q;

  // R8: in driver-enable mode the pin mirrors only the transmitter enable
  p_rts_follows_tx_r8: assert property (@(posedge clk) disable iff (rst)
    (lead_en && $past(lead_en) && $stable(cfg_rts_pol))
      |-> (rts_pin == pin_level(de_q, cfg_rts_pol)));

endmodule

// File: tb/uart_flow_ctrl_tb.sv
`timescale 1ns/1ps
module uart_flow_ctrl_tb;

  localparam int FREE_W = 6;

  logic              clk = 1'b0;
  logic              rst;
  logic              cfg_fc_en;
  logic              cfg_rts_mode;
  logic              cfg_rts_pol;
  logic              cfg_cts_pol;
  logic [FREE_W-1:0] cfg_rx_thresh;
  logic [FREE_W-1:0] rx_free;
  logic              tx_req;
  logic              tx_done;
  logic              tx_start;
  logic              cts_pin;
  logic              rts_pin;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uart_flow_ctrl #(.SYNC_STAGES(2), .FREE_W(FREE_W)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .cfg_fc_en     (cfg_fc_en),
    .cfg_rts_mode  (cfg_rts_mode),
    .cfg_rts_pol   (cfg_rts_pol),
    .cfg_cts_pol   (cfg_cts_pol),
    .cfg_rx_thresh (cfg_rx_thresh),
    .rx_free       (rx_free),
    .tx_req        (tx_req),
    .tx_done       (tx_done),
    .tx_start      (tx_start),
    .cts_pin       (cts_pin),
    .rts_pin       (rts_pin)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic pulse_done();
    tx_done = 1'b1;
    tick();
    tx_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 start low in reset", tx_start, 1'b0);
    chk("R11 rts negated in reset", rts_pin, 1'b1);
    rst = 1'b0;
    tick();
  endtask

  task automatic t_fc_off();
    cfg_fc_en = 1'b0; cfg_rts_mode = 1'b0; cts_pin = 1'b1;
    tick();
    tx_req = 1'b1;
    tick();
    chk("R10 start ignores cts when disabled", tx_start, 1'b1);
    tx_req = 1'b0;
    tick();
    chk("R10 start is one pulse", tx_start, 1'b0);
    repeat (2) tick();
    pulse_done();
  endtask

  task automatic t_cts_gate();
    cfg_fc_en = 1'b1; cfg_rts_mode = 1'b0; cts_pin = 1'b1;
    repeat (3) tick();
    tx_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R1 no start while cts negated", tx_start, 1'b0);
    end
    cts_pin = 1'b0;
    tick(); chk("R2 sync edge 1", tx_start, 1'b0);
    tick(); chk("R2 sync edge 2", tx_start, 1'b0);
    tick(); chk("R2 start on third edge", tx_start, 1'b1);
    tx_req = 1'b0;
    repeat (3) tick();
    pulse_done();
  endtask

  task automatic t_inflight();
    cfg_rts_mode = 1'b0; rx_free = 6'd40;
    tx_req = 1'b1;
    tick();
    chk("R3 first char starts", tx_start, 1'b1);
    cts_pin = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R3 no restart mid char", tx_start, 1'b0);
    end
    pulse_done();
    chk("R3 next char held after done", tx_start, 1'b0);
    chk("R8 rx-mode rts ignores tx", rts_pin, 1'b0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R3 still held", tx_start, 1'b0);
    end
    cts_pin = 1'b0;
    tick(); chk("R3 resume edge 1", tx_start, 1'b0);
    tick(); chk("R3 resume edge 2", tx_start, 1'b0);
    tick(); chk("R3 resume on third edge", tx_start, 1'b1);
    tx_req = 1'b0;
    repeat (3) tick();
    pulse_done();
  endtask

  task automatic t_tx_lead();
    cfg_rts_mode = 1'b1; rx_free = 6'd5;
    tick();
    chk("R8 idle tx-mode rts negated", rts_pin, 1'b1);
    tx_req = 1'b1;
    tick();
    chk("R4 rts on in lead cycle", rts_pin, 1'b0);
    chk("R4 no start in lead cycle", tx_start, 1'b0);
    tick();
    chk("R4 start after lead", tx_start, 1'b1);
    chk("R8 rts on despite full rx", rts_pin, 1'b0);
    tx_req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5 rts held in flight", rts_pin, 1'b0);
    end
    pulse_done();
    chk("R5 rts off after last stop", rts_pin, 1'b1);
    chk("R5 no start after done", tx_start, 1'b0);
  endtask

  task automatic t_tx_b2b();
    tx_req = 1'b1;
    tick(); tick();
    chk("R6 first start", tx_start, 1'b1);
    repeat (2) tick();
    pulse_done();
    chk("R6 next start right after done", tx_start, 1'b1);
    chk("R6 rts held across boundary", rts_pin, 1'b0);
    tx_req = 1'b0;
    tick();
    chk("R6 start single pulse", tx_start, 1'b0);
    tick();
    pulse_done();
    chk("R6 rts off after last", rts_pin, 1'b1);
  endtask

  task automatic t_tx_withdraw();
    tx_req = 1'b1;
    tick(); tick();
    chk("R12 start", tx_start, 1'b1);
    cts_pin = 1'b1;
    repeat (3) tick();
    pulse_done();
    chk("R12 rts held while blocked", rts_pin, 1'b0);
    chk("R12 no start while blocked", tx_start, 1'b0);
    tick();
    chk("R12 rts still held", rts_pin, 1'b0);
    tx_req = 1'b0;
    tick();
    chk("R12 rts off after withdraw", rts_pin, 1'b1);
    cts_pin = 1'b0;
    repeat (3) tick();
  endtask

  task automatic t_rx_hyst();
    cfg_rts_mode = 1'b0; cfg_rx_thresh = 6'd16;
    rx_free = 6'd20; tick(); chk("R7 above threshold asserts", rts_pin, 1'b0);
    rx_free = 6'd16; tick(); chk("R7 equal holds asserted", rts_pin, 1'b0);
    rx_free = 6'd15; tick(); chk("R7 below threshold negates", rts_pin, 1'b1);
    rx_free = 6'd16; tick(); chk("R7 equal holds negated", rts_pin, 1'b1);
    rx_free = 6'd17; tick(); chk("R7 above reasserts", rts_pin, 1'b0);
    rx_free = 6'd0;  tick(); chk("R7 empty space negates", rts_pin, 1'b1);
    rx_free = 6'd63; tick(); chk("R7 max space asserts", rts_pin, 1'b0);
  endtask

  task automatic t_polarity();
    cfg_rts_pol = 1'b1;
    tick(); chk("R9 rts active-high asserted", rts_pin, 1'b1);
    rx_free = 6'd0;
    tick(); chk("R9 rts active-high negated", rts_pin, 1'b0);
    rx_free = 6'd40;
    tick(); chk("R9 rts active-high reasserted", rts_pin, 1'b1);
    cfg_cts_pol = 1'b1; cts_pin = 1'b0;
    repeat (3) tick();
    tx_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R9 low cts is negated when active-high", tx_start, 1'b0);
    end
    cts_pin = 1'b1;
    tick(); tick();
    chk("R9 cts edge 2", tx_start, 1'b0);
    tick();
    chk("R9 high cts starts when active-high", tx_start, 1'b1);
    tx_req = 1'b0;
    repeat (2) tick();
    pulse_done();
    cfg_rts_pol = 1'b0; cfg_cts_pol = 1'b0; cts_pin = 1'b0;
    repeat (3) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_fc_en = 1'b0; cfg_rts_mode = 1'b0;
    cfg_rts_pol = 1'b0; cfg_cts_pol = 1'b0;
    cfg_rx_thresh = 6'd16; rx_free = 6'd40;
    tx_req = 1'b0; tx_done = 1'b0; cts_pin = 1'b1;
    repeat (3) tick();
    t_reset();
    t_fc_off();
    t_cts_gate();
    t_inflight();
    t_tx_lead();
    t_tx_b2b();
    t_tx_withdraw();
    t_rx_hyst();
    t_polarity();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule